// File: doc/BRIEF.md
# SCSI Selection Watcher with Bus Status

This block sits beside a parallel SCSI bus controller and watches the bus while another device selects a target. The host loads a mask with one bit per target ID. When the bit for a masked ID is asserted on the data lines, SEL is asserted and BSY is released, the block raises a sticky interrupt. It can also check data-bus parity on that selection and flag a parity error.

The same block collects a small set of status flags into one read-only byte: a sticky end-of-DMA flag fed by a DMA-complete strobe, a sticky busy-lost flag, the live ATN and ACK lines, a live DMA request and a phase-match input. All SCSI lines are active low and pass through a two-flop synchroniser before any logic sees them. The host reaches the block through a small register window with a 4-bit offset: two write-only mask bytes, one status byte and one clear strobe.

Top module: `scsi_sel_monitor`

## Requirements
- R1: Writing offset 0x4 loads mask bits 7..0 (IDs 0 to 7) and writing offset 0x5 loads mask bits 15..8 (IDs 8 to 15). The mask is write-only, so reads of 0x4 and 0x5 return 0x00.
- R2: The interrupt is set when, for some ID whose mask bit is 1, data line ID is asserted (low), SEL is asserted (low) and BSY is released (high), and this holds for two consecutive synchronised samples. With the inputs held steady, `irq` rises on the fourth rising clock edge after they change.
- R3: A selection condition that lasts for only one clock cycle does not set the interrupt.
- R4: When both mask bytes are 0x00, no selection sets the interrupt.
- R5: No interrupt is raised when the asserted ID is not masked, when BSY is asserted, or when SEL is released.
- R6: The interrupt, parity-error and busy-lost flags stay set until any value is written to offset 0x7. A clear in the same cycle as a new set wins.
- R7: When `par_chk_en` is 1 on the cycle that sets the interrupt, each byte lane is checked for odd parity: the 8 asserted data bits plus that lane's asserted parity line must give an odd count. A mismatch in any lane sets the parity-error flag. When `par_chk_en` is 0, the flag is not set.
- R8: The status byte at offset 0x6 has this layout: bit 7 end of DMA, bit 6 live `dma_req`, bit 5 parity error, bit 4 interrupt, bit 3 live `phase_ok`, bit 2 busy lost, bit 1 ATN asserted, bit 0 ACK asserted.
- R9: `dma_done` sets the end-of-DMA flag while `dma_mode` is 1. The flag is held at 0 whenever `dma_mode` is 0, and `dma_done` has no effect in that case.
- R10: A release of the synchronised BSY line while `dma_mode` is 1 sets the busy-lost flag. A release while `dma_mode` is 0 does not.
- R11: `reg_rdata` is registered and reflects `reg_addr` from the previous cycle. Any offset other than 0x6 reads 0x00.
- R12: After reset, the mask, every sticky flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| scsi_db_n | input | DB_W | Data lines, active low |
| scsi_dbp_n | input | DB_W/8 | Parity line per byte lane, active low |
| scsi_sel_n | input | 1 | SEL, active low |
| scsi_bsy_n | input | 1 | BSY, active low |
| scsi_atn_n | input | 1 | ATN, active low |
| scsi_ack_n | input | 1 | ACK, active low |
| phase_ok | input | 1 | Phase-match indication, shown live |
| dma_req | input | 1 | DMA request, shown live |
| dma_done | input | 1 | DMA-complete strobe |
| dma_mode | input | 1 | DMA mode enable |
| par_chk_en | input | 1 | Enables parity check on selection |
| irq | output | 1 | Selection interrupt (equals status bit 4) |

## Verification
The bench measures the exact edge at which a held selection raises `irq`. It also drives a selection that lasts one cycle, which a design without the two-sample qualifier would latch. It drives selections that miss in each way on the high mask byte: an unmasked line, BSY asserted and SEL released. A design that ignored a term or decoded the wrong mask byte would interrupt on one of them. For parity, the bench uses a case where only the empty upper lane is wrong, which catches even parity or a check of the low lane alone. It also repeats the same bad parity with checking disabled. Random selections with random masks and parity cover the rest. The DMA flags are read right after `dma_mode` drops and after a `dma_done` with the mode off, which exposes a missing clear or an ungated set.

// File: rtl/selmon_pkg.sv
package selmon_pkg;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] ADDR_MASK_LO = 4'h4;
  localparam logic [REG_AW-1:0] ADDR_STATUS  = 4'h6;
  localparam logic [REG_AW-1:0] ADDR_CLR_INT = 4'h7;

  // Field order is bit 7 down to bit 0 of the status byte.
  typedef struct packed {
    logic eod;
    logic dreq;
    logic perr;
    logic irq;
    logic phase;
    logic berr;
    logic atn;
    logic ack;
  } status_t;
endpackage

// File: rtl/selmon_sync.sv
module selmon_sync #(
  parameter int   W       = 8,
  parameter logic RST_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= {W{RST_LVL}};
      d_sync <= {W{RST_LVL}};
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/selmon_match.sv
module selmon_match #(
  parameter int DB_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DB_W-1:0]   db_act,
  input  logic [DB_W/8-1:0] dbp_act,
  input  logic              sel_act,
  input  logic              bsy_act,
  input  logic [DB_W-1:0]   mask,
  output logic              hit,
  output logic              latch_evt,
  output logic              par_bad
);
  localparam int LANES = DB_W / 8;

  logic [LANES-1:0] lane_bad;
  logic             match_q;

  // Odd parity: data bits plus parity line must XOR to 1.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = ~(^{db_act[g*8 +: 8], dbp_act[g]});
  end

  assign par_bad   = |lane_bad;
  assign hit       = (|(mask & db_act)) & sel_act & ~bsy_act;
  assign latch_evt = hit & match_q;

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= hit;
  end
endmodule

// File: rtl/selmon_regs.sv
module selmon_regs
  import selmon_pkg::*;
#(
  parameter int DB_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              latch_evt,
  input  logic              par_bad,
  input  logic              par_chk_en,
  input  logic              bsy_act,
  input  logic              atn_act,
  input  logic              ack_act,
  input  logic              phase_ok,
  input  logic              dma_req,
  input  logic              dma_done,
  input  logic              dma_mode,
  output logic [DB_W-1:0]   mask,
  output status_t           stat
);
  localparam int NBYTES = DB_W / 8;

  logic [7:0] mask_b [NBYTES];
  logic       irq_q, perr_q, berr_q, eod_q, bsy_d;
  logic       clr_int, bsy_fall, first_latch;

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(ADDR_MASK_LO + b);
    always_ff @(posedge clk) begin
      if (rst)                               mask_b[b] <= 8'h00;
      else if (reg_we && reg_addr == MY_ADDR) mask_b[b] <= reg_wdata;
    end
    assign mask[b*8 +: 8] = mask_b[b];
  end

  assign clr_int     = reg_we && (reg_addr == ADDR_CLR_INT);
  assign bsy_fall    = bsy_d & ~bsy_act;
  assign first_latch = latch_evt & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      perr_q <= 1'b0;
      berr_q <= 1'b0;
      eod_q  <= 1'b0;
      bsy_d  <= 1'b0;
    end else begin
      bsy_d  <= bsy_act;
      irq_q  <= clr_int ? 1'b0 : (irq_q | latch_evt);
      perr_q <= clr_int ? 1'b0 : (perr_q | (first_latch & par_chk_en & par_bad));
      berr_q <= clr_int ? 1'b0 : (berr_q | (bsy_fall & dma_mode));
      eod_q  <= dma_mode ? (eod_q | dma_done) : 1'b0;
    end
  end

  always_comb begin
    stat.eod   = eod_q;
    stat.dreq  = dma_req;
    stat.perr  = perr_q;
    stat.irq   = irq_q;
    stat.phase = phase_ok;
    stat.berr  = berr_q;
    stat.atn   = atn_act;
    stat.ack   = ack_act;
  end

  always_ff @(posedge clk) begin
    if (rst)                          reg_rdata <= 8'h00;
    else if (reg_addr == ADDR_STATUS) reg_rdata <= stat;
    else                              reg_rdata <= 8'h00;
  end
endmodule

// File: rtl/scsi_sel_monitor.sv
module scsi_sel_monitor
  import selmon_pkg::*;
#(
  parameter int DB_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [DB_W-1:0]   scsi_db_n,
  input  logic [DB_W/8-1:0] scsi_dbp_n,
  input  logic              scsi_sel_n,
  input  logic              scsi_bsy_n,
  input  logic              scsi_atn_n,
  input  logic              scsi_ack_n,
  input  logic              phase_ok,
  input  logic              dma_req,
  input  logic              dma_done,
  input  logic              dma_mode,
  input  logic              par_chk_en,
  output logic              irq
);
  localparam int LANES = DB_W / 8;
  localparam int SYN_W = DB_W + LANES + 4;

  logic [SYN_W-1:0] bus_sync;
  logic [DB_W-1:0]  db_act;
  logic [LANES-1:0] dbp_act;
  logic             sel_act, bsy_act, atn_act, ack_act;
  logic             sel_hit, latch_evt, par_bad;
  logic [DB_W-1:0]  mask_w;
  status_t          stat_w;

  selmon_sync #(.W(SYN_W), .RST_LVL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({scsi_db_n, scsi_dbp_n, scsi_sel_n, scsi_bsy_n, scsi_atn_n, scsi_ack_n}),
    .d_sync  (bus_sync)
  );

  assign {db_act, dbp_act, sel_act, bsy_act, atn_act, ack_act} = ~bus_sync;

  selmon_match #(.DB_W(DB_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .db_act    (db_act),
    .dbp_act   (dbp_act),
    .sel_act   (sel_act),
    .bsy_act   (bsy_act),
    .mask      (mask_w),
    .hit       (sel_hit),
    .latch_evt (latch_evt),
    .par_bad   (par_bad)
  );

  selmon_regs #(.DB_W(DB_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .latch_evt  (latch_evt),
    .par_bad    (par_bad),
    .par_chk_en (par_chk_en),
    .bsy_act    (bsy_act),
    .atn_act    (atn_act),
    .ack_act    (ack_act),
    .phase_ok   (phase_ok),
    .dma_req    (dma_req),
    .dma_done   (dma_done),
    .dma_mode   (dma_mode),
    .mask       (mask_w),
    .stat       (stat_w)
  );

  assign irq = stat_w.irq;
endmodule

// File: rtl/selmon_checker.sv
module selmon_checker
  import selmon_pkg::*;
#(
  parameter int DB_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_we,
  input logic [7:0]        reg_rdata,
  input logic              dma_mode,
  input logic              par_chk_en,
  input logic              irq,
  input logic              sel_hit,
  input logic [DB_W-1:0]   mask_w,
  input logic              perr,
  input logic              eod
);
  // R2, R3: a rising interrupt needs two consecutive hits under a nonzero mask
  p_two_samples_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(sel_hit) && $past(sel_hit, 2) && ($past(mask_w) != '0)));

  // R4: with an empty mask an idle interrupt stays idle
  p_zero_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (mask_w == '0 && !irq) |=> !irq);

  // R6: interrupt holds unless the clear offset is written
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (irq && !(reg_we && reg_addr == ADDR_CLR_INT)) |=> irq);

  // R7: parity error only appears when checking is enabled
  p_perr_en_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(perr) |-> $past(par_chk_en));

  // R9: end-of-DMA is forced low while DMA mode is off
  p_eod_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |=> !eod);

  // R1: mask offsets read back as zero
  p_mask_wo_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_MASK_LO || reg_addr == REG_AW'(ADDR_MASK_LO + 1)) |=> (reg_rdata == 8'h00));
endmodule

bind scsi_sel_monitor selmon_checker #(.DB_W(DB_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_addr   (reg_addr),
  .reg_we     (reg_we),
  .reg_rdata  (reg_rdata),
  .dma_mode   (dma_mode),
  .par_chk_en (par_chk_en),
  .irq        (irq),
  .sel_hit    (sel_hit),
  .mask_w     (mask_w),
  .perr       (stat_w.perr),
  .eod        (stat_w.eod)
);

// File: tb/scsi_sel_monitor_tb.sv
`timescale 1ns/1ps
module scsi_sel_monitor_tb;
  localparam int DB_W = 16;
  localparam logic [3:0] A_LO = 4'h4, A_HI = 4'h5, A_ST = 4'h6, A_CLR = 4'h7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [15:0] b_db = '0;
  logic [1:0]  b_dbp = '0;
  logic b_sel = 0, b_bsy = 0, b_atn = 0, b_ack = 0;
  logic phase_ok = 0, dma_req = 0, dma_done = 0, dma_mode = 0, par_chk_en = 0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scsi_sel_monitor #(.DB_W(DB_W)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scsi_db_n(~b_db), .scsi_dbp_n(~b_dbp), .scsi_sel_n(~b_sel),
    .scsi_bsy_n(~b_bsy), .scsi_atn_n(~b_atn), .scsi_ack_n(~b_ack), .phase_ok(phase_ok),
    .dma_req(dma_req), .dma_done(dma_done), .dma_mode(dma_mode), .par_chk_en(par_chk_en),
    .irq(irq));

  function automatic logic [1:0] good_par(input logic [15:0] d);
    return {~^d[15:8], ~^d[7:0]};
  endfunction

  function automatic logic exp_hit(input logic [15:0] m, input logic [15:0] d,
                                   input logic s, input logic b);
    return (|(m & d)) & s & ~b;
  endfunction

  function automatic logic exp_pbad(input logic [15:0] d, input logic [1:0] p);
    return (^{d[7:0], p[0]} == 1'b0) || (^{d[15:8], p[1]} == 1'b0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    tick(1);
    d = reg_rdata;
  endtask

  task automatic set_mask(input logic [15:0] m);
    wr(A_LO, m[7:0]);
    wr(A_HI, m[15:8]);
  endtask

  task automatic idle_clear();
    b_db = '0; b_dbp = '0; b_sel = 0; b_bsy = 0;
    tick(4);
    wr(A_CLR, 8'h00);
  endtask

  task automatic drive(input logic [15:0] d, input logic [1:0] p, input logic s, input logic b);
    b_db = d; b_dbp = p; b_sel = s; b_bsy = b;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] m, d;
    logic [1:0] p;
    logic s, b, h, pe;
    void'($urandom(32'd20240611));
    tick(4);
    rst = 1'b0;
    tick(1);

    // R12 reset state
    chk("R12 irq after reset", irq, 0);
    rd(A_ST, v); chk("R12 status after reset", v, 8'h00);
    // R1 mask write-only
    wr(A_LO, 8'hFF);
    rd(A_LO, v); chk("R1 read mask lo", v, 8'h00);
    rd(A_HI, v); chk("R1 read mask hi", v, 8'h00);

    // R2 exact latency on ID 3
    set_mask(16'h0008);
    drive(16'h0008, good_par(16'h0008), 1, 0);
    tick(3); chk("R2 irq before 4th edge", irq, 0);
    tick(1); chk("R2 irq on 4th edge", irq, 1);
    rd(A_ST, v); chk("R2 status irq bit", v, 8'h10);

    // R6 sticky until clear
    drive('0, '0, 0, 0);
    tick(6); chk("R6 irq held after bus idle", irq, 1);
    wr(A_CLR, 8'h5A); chk("R6 irq cleared by write", irq, 0);

    // R3 one-cycle pulse
    drive(16'h0008, good_par(16'h0008), 1, 0);
    tick(1);
    drive('0, '0, 0, 0);
    tick(6); chk("R3 one-cycle selection ignored", irq, 0);

    // R4 empty mask
    set_mask(16'h0000);
    drive(16'hFFFF, good_par(16'hFFFF), 1, 0);
    tick(8); chk("R4 zero mask no irq", irq, 0);
    idle_clear();

    // R5 misses on high byte, then R1/R2 hit on high byte
    set_mask(16'h0100);
    drive(16'h0100, good_par(16'h0100), 1, 1);
    tick(8); chk("R5 bsy asserted no irq", irq, 0);
    idle_clear();
    drive(16'h0100, good_par(16'h0100), 0, 0);
    tick(8); chk("R5 sel released no irq", irq, 0);
    idle_clear();
    drive(16'h0200, good_par(16'h0200), 1, 0);
    tick(8); chk("R5 unmasked id no irq", irq, 0);
    idle_clear();
    drive(16'h0100, good_par(16'h0100), 1, 0);
    tick(8); chk("R1 high mask byte selects id 8", irq, 1);
    idle_clear();

    // R7 parity: only the empty upper lane is wrong
    set_mask(16'h0004);
    par_chk_en = 1;
    drive(16'h0004, 2'b00, 1, 0);
    tick(8); rd(A_ST, v); chk("R7 upper lane parity error", v, 8'h30);
    idle_clear();
    drive(16'h0004, 2'b10, 1, 0);
    tick(8); rd(A_ST, v); chk("R7 good parity no error", v, 8'h10);
    idle_clear();
    par_chk_en = 0;
    drive(16'h0004, 2'b11, 1, 0);
    tick(8); rd(A_ST, v); chk("R7 check disabled no error", v, 8'h10);
    idle_clear();
    rd(A_ST, v); chk("R6 clear drops irq and perr", v, 8'h00);

    // R9 end-of-DMA
    dma_mode = 1; dma_done = 1; tick(1); dma_done = 0;
    tick(1); rd(A_ST, v); chk("R9 eod set", v & 8'h80, 8'h80);
    tick(3); rd(A_ST, v); chk("R9 eod held", v & 8'h80, 8'h80);
    dma_mode = 0; tick(1);
    rd(A_ST, v); chk("R9 eod cleared by mode off", v & 8'h80, 8'h00);
    dma_done = 1; tick(1); dma_done = 0; tick(1);
    rd(A_ST, v); chk("R9 done ignored with mode off", v & 8'h80, 8'h00);

    // R10 busy lost
    dma_mode = 1; b_bsy = 1; tick(5); b_bsy = 0; tick(5);
    rd(A_ST, v); chk("R10 busy lost in dma mode", v & 8'h04, 8'h04);
    wr(A_CLR, 8'h00); dma_mode = 0; tick(1);
    rd(A_ST, v); chk("R10 clear busy lost", v, 8'h00);
    b_bsy = 1; tick(5); b_bsy = 0; tick(5);
    rd(A_ST, v); chk("R10 busy release ignored outside dma", v & 8'h04, 8'h00);

    // R8 live bits
    b_atn = 1; b_ack = 0; phase_ok = 1; dma_req = 1; tick(4);
    rd(A_ST, v); chk("R8 live atn phase dreq", v, 8'h4A);
    b_atn = 0; b_ack = 1; phase_ok = 0; dma_req = 0; tick(4);
    rd(A_ST, v); chk("R8 live ack", v, 8'h01);
    b_ack = 0; tick(4);

    // R11 other offsets read zero
    rd(4'h0, v); chk("R11 offset 0 reads zero", v, 8'h00);
    rd(A_CLR, v); chk("R11 clear offset reads zero", v, 8'h00);

    // Random selections: R2 R5 R7
    for (int i = 0; i < 40; i++) begin
      idle_clear();
      m = 16'($urandom);
      if (i % 4 == 0) m = 16'h1 << ($urandom % 16);
      d = 16'($urandom);
      p = 2'($urandom);
      s = ($urandom % 4) != 0;
      b = ($urandom % 4) == 0;
      pe = 1'($urandom);
      set_mask(m);
      par_chk_en = pe;
      drive(d, p, s, b);
      tick(8);
      h = exp_hit(m, d, s, b);
      chk("R2 random irq", irq, h);
      rd(A_ST, v);
      chk("R7 random status", v, {2'b00, h & pe & exp_pbad(d, p), h, 4'b0000});
    end
    idle_clear();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule